// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block sits between a host or DMA engine and the serial engine of a floppy-style disk controller. It holds up to sixteen bytes of sector data. The host moves bytes into it during a write and out of it during a read. The disk engine takes or delivers one byte per strobe, at the pace of the medium. The block watches the fill level against a programmable service threshold and raises a DMA request when the host should act.

After reset the buffer is switched off and holds a single byte, so it behaves like a plain data register. A configuration load can then enable the full depth and set the threshold. Data moves only while the controller is in its execution phase, and each entry into that phase starts from an empty buffer. The disk engine cannot wait, so two errors are possible. In an overrun, a read byte arrives with no room for it. In an underrun, a write byte is needed and none is buffered. Either error ends the transfer and sets a sticky error flag. An underrun during a write does not stall the medium: the block supplies zero bytes until the disk engine signals the end of the sector, and only then reports the transfer stopped.

Both host data paths use valid/ready. A byte moves in the cycle where valid and ready are both high. The block holds `host_out_valid` and `host_out_data` steady until the byte is taken. `host_in_ready` may fall at any time without loss. The disk side uses single-cycle strobes with no back-pressure.

Top module: `fdc_data_fifo`

## Requirements
- R1: After reset the error flag, stop flag, zero-fill flag and DMA request are low, and both host handshake outputs are low.
- R2: Until a configuration load sets the enable bit, the buffer holds at most one byte, and the service threshold is one byte.
- R3: When enabled, the buffer holds sixteen bytes and hands them to the other side in arrival order. `host_in_ready` falls when sixteen bytes are held.
- R4: In a write transfer (`dir_write`=1), `dma_req` is high while free space (capacity minus level) is at least the threshold. The threshold is field value plus one. It drops once free space falls below the threshold.
- R5: In a read transfer, `dma_req` is high while the level is at least the threshold, or while the transfer is stopped and bytes remain.
- R6: Outside the execution phase (`phase` encoding 0 = command, 1 = execution, 2 = result), no byte moves, disk strobes have no effect, and `dma_req`, `host_in_ready` and `host_out_valid` are low.
- R7: Entering the execution phase empties the buffer. Bytes left from an earlier transfer are never delivered.
- R8: In a read transfer, a disk byte that arrives when the level at the start of the cycle equals the capacity is an overrun. The byte is discarded, and the error and stop flags go high. No later disk byte is stored, but the host can still drain every byte already held.
- R9: In a write transfer, a disk pop while the buffer is empty is an underrun. The error and zero-fill flags go high, `host_in_ready` stays low, and `disk_rd_data` reads 0x00. A sector-end pulse then clears zero-fill and sets the stop flag.
- R10: The error flag stays high until reset or a `cmd_start` pulse. Entering the execution phase does not clear it.
- R11: A host byte moves only while `host_sel` or `dma_ack` is high.
- R12: In a write transfer, `disk_rd_data` shows the oldest held byte, and reads 0x00 when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Loads enable and threshold fields |
| cfg_fifo_en | input | 1 | Enable value: 1 = full depth |
| cfg_thresh | input | 4 | Threshold field (threshold = value + 1) |
| phase | input | 2 | Controller phase: 0 command, 1 execution, 2 result |
| cmd_start | input | 1 | Pulse at the start of a new command |
| dir_write | input | 1 | 1 = host to disk, 0 = disk to host |
| host_sel | input | 1 | Host register access selects the buffer |
| dma_ack | input | 1 | DMA acknowledge, selects the buffer |
| host_in_valid | input | 1 | Host write byte valid |
| host_in_data | input | 8 | Host write byte |
| host_in_ready | output | 1 | Buffer accepts a host byte |
| host_out_valid | output | 1 | Byte available for the host |
| host_out_data | output | 8 | Byte for the host |
| host_out_ready | input | 1 | Host takes the byte |
| dma_req | output | 1 | DMA service request |
| disk_wr_stb | input | 1 | Disk engine delivers a read byte |
| disk_wr_data | input | 8 | Byte from the disk engine |
| disk_rd_stb | input | 1 | Disk engine consumes a write byte |
| disk_rd_data | output | 8 | Byte for the disk engine |
| disk_sector_end | input | 1 | Pulse when the current sector closes |
| xfer_err | output | 1 | Sticky overrun/underrun flag |
| xfer_stop | output | 1 | Transfer ended by an error |
| zero_fill | output | 1 | Padding the sector with zero bytes |

## Verification
The properties assume configuration loads happen only outside the execution phase, and `cmd_start` is pulsed only in the command phase. Under those two rules the level can never exceed the capacity seen by an active transfer. The stimulus obeys both rules: every configuration step and command start first returns `phase` to command. It also changes `dir_write` only while the phase is command.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;
  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;
endpackage

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] level,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // one register slot per entry, written when the write pointer selects it
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && wptr == AW'(e)) mem[e] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rptr];
endmodule

// File: rtl/fdc_fifo_ctrl.sv
module fdc_fifo_ctrl
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_fifo_en,
  input  logic [TW-1:0] cfg_thresh,
  input  logic [1:0]    phase,
  input  logic          cmd_start,
  input  logic          overrun_ev,
  input  logic          underrun_ev,
  input  logic          sector_end,
  output logic          exec_active,
  output logic          flush,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] thr,
  output logic          zfill,
  output logic          stop,
  output logic          err
);
  logic          en_q;
  logic [TW-1:0] thr_q;
  logic          exec_prev;
  logic          in_exec;

  assign in_exec     = (phase == PH_EXEC);
  assign flush       = in_exec && !exec_prev;
  assign exec_active = in_exec && exec_prev;
  assign cap         = en_q ? CW'(DEPTH) : CW'(1);
  assign thr         = en_q ? (CW'(thr_q) + CW'(1)) : CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      thr_q     <= '0;
      exec_prev <= 1'b0;
    end else begin
      exec_prev <= in_exec;
      if (cfg_load) begin
        en_q  <= cfg_fifo_en;
        thr_q <= cfg_thresh;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (cmd_start) begin
      err <= 1'b0;
    end else if (overrun_ev || underrun_ev) begin
      err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zfill <= 1'b0;
      stop  <= 1'b0;
    end else if (flush || cmd_start) begin
      zfill <= 1'b0;
      stop  <= 1'b0;
    end else begin
      if (underrun_ev) zfill <= 1'b1;
      else if (zfill && sector_end) zfill <= 1'b0;
      if (overrun_ev || (zfill && sector_end)) stop <= 1'b1;
    end
  end
endmodule

// File: rtl/fdc_fifo_req.sv
module fdc_fifo_req #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          active,
  input  logic          dir_write,
  input  logic          halted,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] thr,
  output logic          drq
);
  logic [CW-1:0] space;
  logic          want;

  always_comb begin
    space = cap - level;
    if (dir_write) want = !halted && (space >= thr);
    else           want = (level >= thr) || (halted && level != '0);
    drq = active && want;
  end
endmodule

// File: rtl/fdc_data_fifo.sv
module fdc_data_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_fifo_en,
  input  logic [TW-1:0] cfg_thresh,
  input  logic [1:0]    phase,
  input  logic          cmd_start,
  input  logic          dir_write,
  input  logic          host_sel,
  input  logic          dma_ack,
  input  logic          host_in_valid,
  input  logic [DW-1:0] host_in_data,
  output logic          host_in_ready,
  output logic          host_out_valid,
  output logic [DW-1:0] host_out_data,
  input  logic          host_out_ready,
  output logic          dma_req,
  input  logic          disk_wr_stb,
  input  logic [DW-1:0] disk_wr_data,
  input  logic          disk_rd_stb,
  output logic [DW-1:0] disk_rd_data,
  input  logic          disk_sector_end,
  output logic          xfer_err,
  output logic          xfer_stop,
  output logic          zero_fill
);
  logic          exec_active, flush, zfill, stop;
  logic [CW-1:0] level, cap, thr;
  logic [DW-1:0] head;
  logic          sel_any, not_empty, has_room;
  logic          host_in_fire, host_out_fire;
  logic          dpop_try, dpush_try;
  logic          overrun_ev, underrun_ev;
  logic          push, pop;
  logic [DW-1:0] push_data;

  assign sel_any   = host_sel || dma_ack;
  assign not_empty = (level != '0);
  assign has_room  = (level < cap);

  // host side handshakes
  assign host_in_ready  = exec_active && dir_write && sel_any && !stop && !zfill && has_room;
  assign host_in_fire   = host_in_valid && host_in_ready;
  assign host_out_valid = exec_active && !dir_write && sel_any && not_empty;
  assign host_out_fire  = host_out_valid && host_out_ready;
  assign host_out_data  = head;

  // disk side strobes and error detection
  assign dpop_try    = exec_active && dir_write && !stop && !zfill && disk_rd_stb;
  assign dpush_try   = exec_active && !dir_write && !stop && disk_wr_stb;
  assign underrun_ev = dpop_try && !not_empty;
  assign overrun_ev  = dpush_try && !has_room;

  assign push      = dir_write ? host_in_fire : (dpush_try && has_room);
  assign push_data = dir_write ? host_in_data : disk_wr_data;
  assign pop       = dir_write ? (dpop_try && not_empty) : host_out_fire;

  assign disk_rd_data = (exec_active && dir_write && !zfill && not_empty) ? head : '0;

  assign xfer_err  = u_ctrl.err;
  assign xfer_stop = stop;
  assign zero_fill = zfill;

  fdc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_thresh  (cfg_thresh),
    .phase       (phase),
    .cmd_start   (cmd_start),
    .overrun_ev  (overrun_ev),
    .underrun_ev (underrun_ev),
    .sector_end  (disk_sector_end),
    .exec_active (exec_active),
    .flush       (flush),
    .cap         (cap),
    .thr         (thr),
    .zfill       (zfill),
    .stop        (stop),
    .err         ()
  );

  fdc_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .level     (level),
    .head      (head)
  );

  fdc_fifo_req #(.DEPTH(DEPTH)) u_req (
    .active    (exec_active),
    .dir_write (dir_write),
    .halted    (stop || zfill),
    .level     (level),
    .cap       (cap),
    .thr       (thr),
    .drq       (dma_req)
  );
endmodule

// File: rtl/fdc_data_fifo_chk.sv
module fdc_data_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic          cmd_start,
  input logic          dir_write,
  input logic          host_in_ready,
  input logic          host_out_valid,
  input logic          dma_req,
  input logic [DW-1:0] disk_rd_data,
  input logic          xfer_err,
  input logic          xfer_stop,
  input logic          zero_fill,
  input logic          exec_active,
  input logic          flush,
  input logic [CW-1:0] level,
  input logic [CW-1:0] cap
);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_active |-> level <= cap);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd1) |-> (!dma_req && !host_in_ready && !host_out_valid));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_err && !cmd_start) |=> xfer_err);

  // R9
  zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fill |-> (disk_rd_data == '0 && !host_in_ready));

  // R8
  stop_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stop && !dir_write && !flush && !cmd_start) |=> (level <= $past(level)));
endmodule

bind fdc_data_fifo fdc_data_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .phase          (phase),
  .cmd_start      (cmd_start),
  .dir_write      (dir_write),
  .host_in_ready  (host_in_ready),
  .host_out_valid (host_out_valid),
  .dma_req        (dma_req),
  .disk_rd_data   (disk_rd_data),
  .xfer_err       (xfer_err),
  .xfer_stop      (xfer_stop),
  .zero_fill      (zero_fill),
  .exec_active    (exec_active),
  .flush          (flush),
  .level          (level),
  .cap            (cap)
);

// File: tb/fdc_data_fifo_tb.sv
module fdc_data_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 0, cfg_fifo_en = 0;
  logic [3:0] cfg_thresh = '0;
  logic [1:0] phase = 2'd0;
  logic       cmd_start = 0, dir_write = 0, host_sel = 0, dma_ack = 0;
  logic       host_in_valid = 0, host_out_ready = 0;
  logic [7:0] host_in_data = '0, disk_wr_data = '0;
  logic       disk_wr_stb = 0, disk_rd_stb = 0, disk_sector_end = 0;
  logic       host_in_ready, host_out_valid, dma_req, xfer_err, xfer_stop, zero_fill;
  logic [7:0] host_out_data, disk_rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fdc_data_fifo u_dut (.*);

  // {dir_write, thr field, fill level, expected dma_req}
  localparam logic [10:0] VEC [13] = '{
    {1'b1, 4'd0,  5'd0,  1'b1}, {1'b1, 4'd0,  5'd15, 1'b1}, {1'b1, 4'd0,  5'd16, 1'b0},
    {1'b1, 4'd7,  5'd8,  1'b1}, {1'b1, 4'd7,  5'd9,  1'b0}, {1'b1, 4'd15, 5'd0,  1'b1},
    {1'b1, 4'd15, 5'd1,  1'b0}, {1'b0, 4'd0,  5'd0,  1'b0}, {1'b0, 4'd0,  5'd1,  1'b1},
    {1'b0, 4'd7,  5'd7,  1'b0}, {1'b0, 4'd7,  5'd8,  1'b1}, {1'b0, 4'd15, 5'd15, 1'b0},
    {1'b0, 4'd15, 5'd16, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic configure(input bit en, input logic [3:0] th);
    phase = 2'd0; cfg_load = 1; cfg_fifo_en = en; cfg_thresh = th;
    tick();
    cfg_load = 0;
  endtask

  task automatic enter_exec(input bit wr);
    phase = 2'd0; cmd_start = 1; dir_write = wr;
    tick();
    cmd_start = 0; phase = 2'd1;
    tick(2);
  endtask

  task automatic host_write(input logic [7:0] b);
    host_sel = 1; host_in_valid = 1; host_in_data = b;
    tick();
    host_in_valid = 0;
  endtask

  task automatic disk_push(input logic [7:0] b);
    disk_wr_stb = 1; disk_wr_data = b;
    tick();
    disk_wr_stb = 0;
  endtask

  task automatic disk_pop(output logic [7:0] b);
    b = disk_rd_data;
    disk_rd_stb = 1;
    tick();
    disk_rd_stb = 0;
  endtask

  task automatic host_read(output logic [7:0] b);
    host_sel = 1; b = host_out_data; host_out_ready = 1;
    tick();
    host_out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(!xfer_err && !xfer_stop && !zero_fill, "R1 flags", {xfer_err, xfer_stop, zero_fill}, 0);
    chk(!dma_req && !host_in_ready && !host_out_valid, "R1 handshake", {dma_req, host_in_ready, host_out_valid}, 0);

    // R2 byte mode after reset, R12 head byte to disk
    enter_exec(1);
    host_sel = 1; tick();
    chk(host_in_ready == 1, "R2 ready empty", host_in_ready, 1);
    host_write(8'h5A);
    chk(host_in_ready == 0, "R2 one byte cap", host_in_ready, 0);
    chk(dma_req == 0, "R2 thr one", dma_req, 0);
    chk(disk_rd_data == 8'h5A, "R12 head", disk_rd_data, 8'h5A);
    disk_pop(b);
    chk(disk_rd_data == 8'h00, "R12 empty zero", disk_rd_data, 0);
    chk(host_in_ready == 1, "R2 ready again", host_in_ready, 1);

    // R11 selection required
    host_sel = 0; tick();
    chk(host_in_ready == 0, "R11 no select", host_in_ready, 0);
    dma_ack = 1; tick();
    chk(host_in_ready == 1, "R11 dma ack", host_in_ready, 1);
    dma_ack = 0;

    // R4 R5 threshold table
    foreach (VEC[k]) begin
      configure(1'b1, VEC[k][9:6]);
      enter_exec(VEC[k][10]);
      for (int i = 0; i < int'(VEC[k][5:1]); i++) begin
        if (VEC[k][10]) host_write(8'(i)); else disk_push(8'(i));
      end
      host_sel = 0; tick();
      chk(dma_req == VEC[k][0], VEC[k][10] ? "R4 write drq" : "R5 read drq", dma_req, VEC[k][0]);
    end

    // R3 full depth and order
    configure(1'b1, 4'd0);
    enter_exec(1);
    for (int i = 0; i < 16; i++) host_write(8'hA0 + 8'(i));
    chk(host_in_ready == 0, "R3 full", host_in_ready, 0);
    for (int i = 0; i < 16; i++) begin
      disk_pop(b);
      chk(b == 8'hA0 + 8'(i), "R3 order", b, 8'hA0 + i);
    end

    // R6 strobes ignored outside execution
    phase = 2'd0; tick();
    disk_rd_stb = 1; tick(); disk_rd_stb = 0; tick();
    chk(xfer_err == 0, "R6 strobe ignored", xfer_err, 0);
    chk(!dma_req && !host_in_ready, "R6 quiet", {dma_req, host_in_ready}, 0);

    // R7 flush on entry
    enter_exec(0);
    for (int i = 0; i < 3; i++) disk_push(8'h10 + 8'(i));
    phase = 2'd2; tick();
    phase = 2'd1; tick(2);
    host_sel = 1; tick();
    chk(host_out_valid == 0, "R7 flushed", host_out_valid, 0);
    host_sel = 0;

    // R8 overrun, R5 drain after stop
    configure(1'b1, 4'd15);
    enter_exec(0);
    for (int i = 0; i < 16; i++) disk_push(8'hC0 + 8'(i));
    chk(xfer_err == 0, "R8 no early error", xfer_err, 0);
    disk_push(8'hEE);
    chk(xfer_err && xfer_stop, "R8 overrun flags", {xfer_err, xfer_stop}, 3);
    for (int i = 0; i < 15; i++) begin
      host_read(b);
      chk(b == 8'hC0 + 8'(i), "R8 drain data", b, 8'hC0 + i);
    end
    chk(dma_req == 1, "R5 drain request", dma_req, 1);
    host_read(b);
    chk(b == 8'hCF, "R8 last byte", b, 8'hCF);
    disk_push(8'h77);
    chk(host_out_valid == 0, "R8 push ignored", host_out_valid, 0);
    chk(dma_req == 0, "R5 drained", dma_req, 0);

    // R10 sticky error
    host_sel = 0;
    phase = 2'd0; tick(); phase = 2'd1; tick(2);
    chk(xfer_err == 1 && xfer_stop == 0, "R10 survives flush", {xfer_err, xfer_stop}, 2);
    enter_exec(1);
    chk(xfer_err == 0, "R10 cleared", xfer_err, 0);

    // R9 underrun with zero fill
    configure(1'b1, 4'd3);
    enter_exec(1);
    host_write(8'h31); host_write(8'h32);
    disk_pop(b); disk_pop(b);
    chk(b == 8'h32, "R9 data before", b, 8'h32);
    disk_pop(b);
    chk(xfer_err && zero_fill && !xfer_stop, "R9 underrun", {xfer_err, zero_fill, xfer_stop}, 6);
    chk(host_in_ready == 0, "R9 host blocked", host_in_ready, 0);
    disk_pop(b);
    chk(b == 8'h00, "R9 zero byte", b, 0);
    disk_sector_end = 1; tick(); disk_sector_end = 0;
    chk(!zero_fill && xfer_stop, "R9 sector close", {zero_fill, xfer_stop}, 1);
    chk(host_in_ready == 0, "R9 stopped", host_in_ready, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule